// File: doc/BRIEF.md
# Wake-up Oscillator Stabilization Sequencer

This block sequences a device out of its low-power sleep state. While the CPU runs, a sleep request parks the device: the high-speed oscillator is switched off and the CPU is held. An external wake interrupt ends sleep and restarts the oscillator at once.

If the wait function is enabled (active-low configuration input at 0), the sequencer also issues a one-cycle load command to a general-purpose down-counter, in the same cycle the oscillator starts. It then keeps the CPU held until that counter reports an underflow, so code never runs on an unsettled clock. With the wait function bypassed (input at 1), the CPU is released in the first cycle after the wake interrupt. A sleep request that comes during the stabilization wait is remembered and acted on once the CPU has been released.

Top module: `wake_seq`

## Requirements
- R1: While rst_ni is low, and after it is released, the block is in the running state: osc_en_o=1, cpu_run_o=1, tmr_load_o=0.
- R2: In the running state, sleep_req_i=1 at a clock edge gives osc_en_o=0 and cpu_run_o=0 from that edge on. This holds even if wake_irq_i is high in the same cycle.
- R3: In the sleep state, the outputs stay osc_en_o=0, cpu_run_o=0 until wake_irq_i=1. sleep_req_i and tmr_uflow_i have no effect there, and a sleep request seen during sleep is not remembered.
- R4: In the sleep state, wake_irq_i=1 with wait_dis_i=1 (wait bypassed) gives osc_en_o=1 and cpu_run_o=1 in the next cycle, with no load pulse.
- R5: In the sleep state, wake_irq_i=1 with wait_dis_i=0 (wait enabled) enters the wait state. Then osc_en_o=1 and cpu_run_o=0, and tmr_load_o=1 for exactly the first cycle of the wait. A wake interrupt takes priority over a sleep request in the same cycle.
- R6: In the wait state, tmr_uflow_i=1 gives cpu_run_o=1 in the next cycle. Without an underflow, cpu_run_o stays 0 however long the wait lasts.
- R7: An underflow seen in the cycle where tmr_load_o=1 is ignored, because the counter has only just been loaded.
- R8: wake_irq_i has no effect in the running state.
- R9: sleep_req_i during the wait state is held. After release, cpu_run_o is 1 for exactly one cycle, then the block enters sleep. The held request is consumed by that entry.
- R10: wait_dis_i is sampled only when the wake interrupt arrives. Changing it during the wait does not release the CPU.
- R11: cpu_run_o is never 1 while osc_en_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_req_i | input | 1 | Request to enter sleep |
| wake_irq_i | input | 1 | External wake interrupt |
| wait_dis_i | input | 1 | Stabilization wait: 0 enabled, 1 bypassed |
| tmr_uflow_i | input | 1 | Underflow from the stabilization counter |
| osc_en_o | output | 1 | High-speed oscillator enable |
| tmr_load_o | output | 1 | One-cycle command to load and start the counter |
| cpu_run_o | output | 1 | CPU allowed to run |

## Verification
The checker assumes that all inputs are synchronous to clk_i and settle before each rising edge. It also assumes that tmr_uflow_i comes only from a counter the block has loaded, so an underflow pulse during sleep or while running is meaningless and is not checked for effect beyond R3.

The stimulus changes inputs only on falling edges and holds each vector for a single cycle. Underflows are placed only where a real counter could produce them, except for deliberate probes of R3 and R7.

// File: rtl/wake_seq_pkg.sv
package wake_seq_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_WAIT  = 2'd2
  } wake_state_e;
endpackage

// File: rtl/wake_sleep_hold.sv
module wake_sleep_hold
  import wake_seq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  wake_state_e state_q_i,
  input  logic        sleep_req_i,
  output logic        sleep_go_o
);
  logic pend_q;

  // latch requests made during the wait; consumed once back in run
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                pend_q <= 1'b0;
    else if (state_q_i == ST_RUN)               pend_q <= 1'b0;
    else if (state_q_i == ST_WAIT && sleep_req_i) pend_q <= 1'b1;
  end

  assign sleep_go_o = sleep_req_i | pend_q;
endmodule

// File: rtl/wake_fsm.sv
module wake_fsm
  import wake_seq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sleep_go_i,
  input  logic        wake_irq_i,
  input  logic        wait_dis_i,
  input  logic        tmr_uflow_i,
  input  logic        load_q_i,
  output wake_state_e state_d_o,
  output wake_state_e state_q_o
);
  wake_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:   if (sleep_go_i) state_d = ST_SLEEP;
      ST_SLEEP: if (wake_irq_i) state_d = wait_dis_i ? ST_RUN : ST_WAIT;
      // underflow in the load cycle is stale
      ST_WAIT:  if (tmr_uflow_i && !load_q_i) state_d = ST_RUN;
      default:  state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RUN;
    else         state_q <= state_d;
  end

  assign state_d_o = state_d;
  assign state_q_o = state_q;
endmodule

// File: rtl/wake_out.sv
module wake_out
  import wake_seq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  wake_state_e state_d_i,
  input  wake_state_e state_q_i,
  output logic        load_q_o,
  output logic        osc_en_o,
  output logic        cpu_run_o
);
  logic load_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) load_q <= 1'b0;
    else         load_q <= (state_d_i == ST_WAIT) && (state_q_i != ST_WAIT);
  end

  assign load_q_o  = load_q;
  assign osc_en_o  = (state_q_i != ST_SLEEP);
  assign cpu_run_o = (state_q_i == ST_RUN);
endmodule

// File: rtl/wake_seq.sv
module wake_seq
  import wake_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_req_i,
  input  logic wake_irq_i,
  input  logic wait_dis_i,
  input  logic tmr_uflow_i,
  output logic osc_en_o,
  output logic tmr_load_o,
  output logic cpu_run_o
);
  wake_state_e state_d, state_q;
  logic        sleep_go, load_q;

  wake_sleep_hold u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_q_i   (state_q),
    .sleep_req_i (sleep_req_i),
    .sleep_go_o  (sleep_go)
  );

  wake_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sleep_go_i  (sleep_go),
    .wake_irq_i  (wake_irq_i),
    .wait_dis_i  (wait_dis_i),
    .tmr_uflow_i (tmr_uflow_i),
    .load_q_i    (load_q),
    .state_d_o   (state_d),
    .state_q_o   (state_q)
  );

  wake_out u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_d_i (state_d),
    .state_q_i (state_q),
    .load_q_o  (load_q),
    .osc_en_o  (osc_en_o),
    .cpu_run_o (cpu_run_o)
  );

  assign tmr_load_o = load_q;
endmodule

// File: rtl/wake_seq_chk.sv
module wake_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sleep_req_i,
  input logic wake_irq_i,
  input logic wait_dis_i,
  input logic tmr_uflow_i,
  input logic osc_en_o,
  input logic tmr_load_o,
  input logic cpu_run_o
);
  // R2
  run_to_sleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_run_o && sleep_req_i) |=> (!osc_en_o && !cpu_run_o));

  // R3
  sleep_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!osc_en_o && !wake_irq_i) |=> (!osc_en_o && !cpu_run_o));

  // R4
  bypass_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!osc_en_o && wake_irq_i && wait_dis_i) |=> (cpu_run_o && !tmr_load_o));

  // R5
  wait_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!osc_en_o && wake_irq_i && !wait_dis_i) |=> (osc_en_o && tmr_load_o && !cpu_run_o));

  // R5
  load_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_load_o |=> !tmr_load_o);

  // R6
  uflow_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_en_o && !cpu_run_o && !tmr_load_o && tmr_uflow_i) |=> cpu_run_o);

  // R7
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_en_o && !cpu_run_o && (!tmr_uflow_i || tmr_load_o)) |=> (osc_en_o && !cpu_run_o));

  // R11
  run_needs_osc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_run_o |-> osc_en_o);
endmodule

bind wake_seq wake_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sleep_req_i (sleep_req_i),
  .wake_irq_i  (wake_irq_i),
  .wait_dis_i  (wait_dis_i),
  .tmr_uflow_i (tmr_uflow_i),
  .osc_en_o    (osc_en_o),
  .tmr_load_o  (tmr_load_o),
  .cpu_run_o   (cpu_run_o)
);

// File: tb/sim_wake_seq.sv
module sim_wake_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0, wake_irq = 1'b0, wait_dis = 1'b0, uflow = 1'b0;
  logic osc_en, tmr_load, cpu_run;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wake_seq u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .sleep_req_i (sleep_req),
    .wake_irq_i  (wake_irq),
    .wait_dis_i  (wait_dis),
    .tmr_uflow_i (uflow),
    .osc_en_o    (osc_en),
    .tmr_load_o  (tmr_load),
    .cpu_run_o   (cpu_run)
  );

  // {sleep, wake, dis, uflow, exp_osc, exp_load, exp_run}
  localparam int NV = 22;
  localparam logic [6:0] VEC [NV] = '{
    7'b0000_101, // 0  R1 idle in run
    7'b0100_101, // 1  R8 wake ignored in run
    7'b1000_000, // 2  R2 sleep
    7'b1000_000, // 3  R3 sleep req in sleep
    7'b0001_000, // 4  R3 uflow in sleep
    7'b0110_101, // 5  R4 bypass wake
    7'b1000_000, // 6  R2
    7'b0100_110, // 7  R5 wait entry with load
    7'b0001_100, // 8  R7 uflow in load cycle ignored
    7'b0010_100, // 9  R10 dis change in wait
    7'b1000_100, // 10 R9 sleep req in wait held
    7'b0001_101, // 11 R6 release
    7'b0000_000, // 12 R9 held request acts
    7'b0100_110, // 13 R5
    7'b0000_100, // 14 R6 hold
    7'b0001_101, // 15 R6
    7'b0000_101, // 16 R9 request consumed
    7'b1100_000, // 17 R2 sleep wins in run
    7'b1100_110, // 18 R5 wake wins in sleep
    7'b0000_100, // 19 R6
    7'b0001_101, // 20 R6
    7'b0000_101  // 21 R3 not remembered
  };

  task automatic check(input string tag, input logic [2:0] exp);
    n_chk++;
    if ({osc_en, tmr_load, cpu_run} !== exp) begin
      n_bad++;
      $display("FAIL %s: osc/load/run=%b expected %b", tag, {osc_en, tmr_load, cpu_run}, exp);
    end
  endtask

  task automatic drive(input logic [3:0] v);
    {sleep_req, wake_irq, wait_dis, uflow} = v;
    @(negedge clk);
  endtask

  initial begin
    #1 check("R1 in reset", 3'b101);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check("R1 after release", 3'b101);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][6:3]);
      check($sformatf("vector %0d", i), VEC[i][2:0]);
    end

    // R6: long wait without underflow
    drive(4'b1000);
    drive(4'b0100);
    for (int i = 0; i < 50; i++) drive(4'b0000);
    check("R6 long wait", 3'b100);

    // R1: asynchronous reset mid-wait
    #3 rst_n = 1'b0;
    #1 check("R1 async reset", 3'b101);
    @(negedge clk);
    rst_n = 1'b1;
    drive(4'b0000);
    check("R1 run after reset", 3'b101);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: timeout actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule